// File: doc/BRIEF.md
# Configurable Output Port Multiplexer

This block drives the eight general-purpose output pins of a dual-channel serial controller. It holds two byte-wide registers that a simple parallel bus writes: a pin-data register and a pin-mode register. With the mode register cleared, every pin shows the inverse of its pin-data bit. Setting mode bits lets pins 2 through 7 carry internal signals instead. These are the transmitter and receiver interrupt status bits (inverted), the counter/timer output, or the baud-rate clocks of either channel. Pins 0 and 1 always follow the pin-data register.

Each pin leaves the block as a drive value plus an output enable. A pin that carries an interrupt or the counter/timer output behaves as open-drain: it only pulls low and otherwise releases. Every other source drives both levels. In counter mode the counter/timer output is a latch. It falls on a terminal-count pulse and rises again only on a stop-command pulse. In timer mode it follows the incoming square wave.

Top module: `outport_mux`

## Requirements
- R1: After reset both registers hold 0x00, so every `pin_val` bit is 1 and every `pin_oe` bit is 1; the counter latch starts high.
- R2: A cycle with `bus_we`=1 loads `bus_wdata` into the pin-data register (`bus_addr`=0) or the pin-mode register (`bus_addr`=1) at the clock edge. A cycle with `bus_we`=0 changes neither register.
- R3: Pins 0 and 1 always drive the inverse of pin-data bits 0 and 1 with `pin_oe`=1, whatever the pin-mode register holds.
- R4: Pin-mode bit k (k=4..7) set makes pin k carry the inverse of status bit s. The pairs (k,s) are (4,1) channel A receive, (5,5) channel B receive, (6,0) channel A transmit and (7,4) channel B transmit. With the bit clear, pin k carries the inverse of pin-data bit k.
- R5: A pin carrying an interrupt or the counter/timer output has `pin_oe`=1 only when its value is 0. Every other pin has `pin_oe`=1 at all times.
- R6: Pin-mode bits [3:2] pick the pin 3 source. 00 is the inverse of pin-data bit 3, 01 is the counter/timer output (open-drain), 10 is the channel B transmit 1x clock, and 11 is the channel B receive 1x clock.
- R7: Pin-mode bits [1:0] pick the pin 2 source. 00 is the inverse of pin-data bit 2, 01 is the channel A transmit 16x clock, 10 is the channel A transmit 1x clock, and 11 is the channel A receive 1x clock. Under 01, when `a_clk_sel` is 4'b1111 the channel A transmit 1x clock is shown instead.
- R8: With `ct_timer_mode`=0, the counter/timer output goes low in the cycle after a `ct_tc` pulse. It stays low until a `ct_stop` pulse, after which it is high from the next cycle.
- R9: When `ct_tc` and `ct_stop` are high in the same cycle, the counter latch ends high.
- R10: With `ct_timer_mode`=1 the counter/timer output follows `ct_sq_wave` in the same cycle.
- R11: Status bits 2, 3, 6 and 7 have no effect on any pin. No interrupt mask exists, so the routed status bits reach the pins unfiltered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 1 | 0 = pin-data register, 1 = pin-mode register |
| bus_wdata | input | 8 | Write data |
| irq_stat | input | 8 | Unmasked interrupt status bits |
| ct_timer_mode | input | 1 | 1 = timer (square wave), 0 = counter latch |
| ct_sq_wave | input | 1 | Timer square wave |
| ct_tc | input | 1 | Terminal-count pulse |
| ct_stop | input | 1 | Stop-command pulse |
| a_clk_sel | input | 4 | Channel A transmit clock-select field |
| a_tx16_clk | input | 1 | Channel A transmit 16x clock |
| a_tx1_clk | input | 1 | Channel A transmit 1x clock |
| a_rx1_clk | input | 1 | Channel A receive 1x clock |
| b_tx1_clk | input | 1 | Channel B transmit 1x clock |
| b_rx1_clk | input | 1 | Channel B receive 1x clock |
| pin_val | output | 8 | Drive value per pin |
| pin_oe | output | 8 | Output enable per pin |

## Verification
The bench builds the block with its default parameters. These are an 8-bit status vector, routed status positions 0, 1, 4 and 5, and a 4-bit clock-select field whose all-ones code triggers the 1x substitution. With these values the four unrouted status bits exist on the port, so random and directed toggling of them shows that they never reach a pin. The all-ones clock-select code is forced often enough that both arms of the pin 2 substitution are seen. Terminal-count and stop pulses are drawn independently, so they land together in some cycles and the stop priority of the latch is exercised alongside the directed case.

// File: rtl/outport_pkg.sv
package outport_pkg;

   localparam int unsigned PIN_COUNT = 8;

   localparam logic ADDR_PIN_DATA = 1'b0;
   localparam logic ADDR_PIN_MODE = 1'b1;

   typedef enum logic [1:0] {
      P2_DATA   = 2'b00,
      P2_ATX16  = 2'b01,
      P2_ATX1X  = 2'b10,
      P2_ARX1X  = 2'b11
   } p2_sel_e;

   typedef enum logic [1:0] {
      P3_DATA   = 2'b00,
      P3_CT     = 2'b01,
      P3_BTX1X  = 2'b10,
      P3_BRX1X  = 2'b11
   } p3_sel_e;

   typedef struct packed {
      logic val;
      logic od;
   } pin_src_t;

endpackage

// File: rtl/outport_regs.sv
module outport_regs #(
   parameter int unsigned DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic          addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] dat_q,
   output logic [DW-1:0] cfg_q
);
   import outport_pkg::*;

   logic wr_dat;
   logic wr_cfg;

   assign wr_dat = we && (addr == ADDR_PIN_DATA);
   assign wr_cfg = we && (addr == ADDR_PIN_MODE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dat_q <= '0;
      end else if (wr_dat) begin
         dat_q <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else if (wr_cfg) begin
         cfg_q <= wdata;
      end
   end

endmodule

// File: rtl/outport_ct_latch.sv
module outport_ct_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic timer_mode,
   input  logic sq_wave,
   input  logic tc,
   input  logic stop,
   output logic hold_q,
   output logic ct_out
);

   logic hold_d;

   always_comb begin
      hold_d = hold_q;
      if (stop) begin
         hold_d = 1'b1;
      end else if (tc) begin
         hold_d = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= 1'b1;
      end else begin
         hold_q <= hold_d;
      end
   end

   assign ct_out = timer_mode ? sq_wave : hold_q;

endmodule

// File: rtl/outport_pin_sel.sv
module outport_pin_sel
   import outport_pkg::*;
#(
   parameter int unsigned DW      = 8,
   parameter int unsigned STAT_W  = 8,
   parameter int unsigned CSEL_W  = 4,
   parameter int unsigned ATX_BIT = 0,
   parameter int unsigned ARX_BIT = 1,
   parameter int unsigned BTX_BIT = 4,
   parameter int unsigned BRX_BIT = 5
) (
   input  logic [DW-1:0]     cfg,
   input  logic [DW-1:0]     dat,
   input  logic [STAT_W-1:0] stat,
   input  logic              ct_out,
   input  logic [CSEL_W-1:0] a_csel,
   input  logic              a_tx16,
   input  logic              a_tx1,
   input  logic              a_rx1,
   input  logic              b_tx1,
   input  logic              b_rx1,
   output pin_src_t [DW-1:0] src
);

   localparam logic [CSEL_W-1:0] CSEL_1X = '1;

   function automatic int unsigned stat_idx(input int unsigned pin);
      case (pin)
         4:       return ARX_BIT;
         5:       return BRX_BIT;
         6:       return ATX_BIT;
         default: return BTX_BIT;
      endcase
   endfunction

   logic unused_stat;
   assign unused_stat = ^stat;

   genvar gi;
   generate
      for (gi = 0; gi < DW; gi++) begin : g_pin
         if (gi < 2) begin : g_fixed
            assign src[gi] = '{val: ~dat[gi], od: 1'b0};
         end else if (gi == 2) begin : g_p2
            p2_sel_e sel;
            logic    tx16_eff;
            assign sel      = p2_sel_e'(cfg[1:0]);
            assign tx16_eff = (a_csel == CSEL_1X) ? a_tx1 : a_tx16;
            always_comb begin
               src[gi].od = 1'b0;
               unique case (sel)
                  P2_DATA:  src[gi].val = ~dat[gi];
                  P2_ATX16: src[gi].val = tx16_eff;
                  P2_ATX1X: src[gi].val = a_tx1;
                  P2_ARX1X: src[gi].val = a_rx1;
               endcase
            end
         end else if (gi == 3) begin : g_p3
            p3_sel_e sel;
            assign sel = p3_sel_e'(cfg[3:2]);
            always_comb begin
               src[gi].od = (sel == P3_CT);
               unique case (sel)
                  P3_DATA:  src[gi].val = ~dat[gi];
                  P3_CT:    src[gi].val = ct_out;
                  P3_BTX1X: src[gi].val = b_tx1;
                  P3_BRX1X: src[gi].val = b_rx1;
               endcase
            end
         end else begin : g_irq
            localparam int unsigned SIDX = stat_idx(gi);
            assign src[gi] = cfg[gi] ? '{val: ~stat[SIDX], od: 1'b1}
                                     : '{val: ~dat[gi],    od: 1'b0};
         end
      end
   endgenerate

endmodule

// File: rtl/outport_od_drv.sv
module outport_od_drv
   import outport_pkg::*;
#(
   parameter int unsigned DW = 8
) (
   input  pin_src_t [DW-1:0] src,
   output logic     [DW-1:0] pin_val,
   output logic     [DW-1:0] pin_oe
);

   genvar gi;
   generate
      for (gi = 0; gi < DW; gi++) begin : g_drv
         assign pin_val[gi] = src[gi].val;
         assign pin_oe[gi]  = src[gi].od ? ~src[gi].val : 1'b1;
      end
   endgenerate

endmodule

// File: rtl/outport_mux.sv
module outport_mux #(
   parameter int unsigned DW      = 8,
   parameter int unsigned STAT_W  = 8,
   parameter int unsigned CSEL_W  = 4,
   parameter int unsigned ATX_BIT = 0,
   parameter int unsigned ARX_BIT = 1,
   parameter int unsigned BTX_BIT = 4,
   parameter int unsigned BRX_BIT = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic              bus_addr,
   input  logic [DW-1:0]     bus_wdata,
   input  logic [STAT_W-1:0] irq_stat,
   input  logic              ct_timer_mode,
   input  logic              ct_sq_wave,
   input  logic              ct_tc,
   input  logic              ct_stop,
   input  logic [CSEL_W-1:0] a_clk_sel,
   input  logic              a_tx16_clk,
   input  logic              a_tx1_clk,
   input  logic              a_rx1_clk,
   input  logic              b_tx1_clk,
   input  logic              b_rx1_clk,
   output logic [DW-1:0]     pin_val,
   output logic [DW-1:0]     pin_oe
);
   import outport_pkg::*;

   localparam int unsigned MAX_SIDX =
      ((ATX_BIT > ARX_BIT) ? ATX_BIT : ARX_BIT) > ((BTX_BIT > BRX_BIT) ? BTX_BIT : BRX_BIT)
      ? ((ATX_BIT > ARX_BIT) ? ATX_BIT : ARX_BIT)
      : ((BTX_BIT > BRX_BIT) ? BTX_BIT : BRX_BIT);

   generate
      if (DW != PIN_COUNT) begin : g_bad_dw
         $error("outport_mux: DW must equal the pin count of 8");
      end
      if (MAX_SIDX >= STAT_W) begin : g_bad_sidx
         $error("outport_mux: a status bit index lies outside STAT_W");
      end
      if (CSEL_W < 1) begin : g_bad_csel
         $error("outport_mux: CSEL_W must be at least 1");
      end
   endgenerate

   logic [DW-1:0]     dat_q;
   logic [DW-1:0]     cfg_q;
   logic              ct_hold;
   logic              ct_out;
   pin_src_t [DW-1:0] src;

   outport_regs #(.DW(DW)) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (bus_we),
      .addr  (bus_addr),
      .wdata (bus_wdata),
      .dat_q (dat_q),
      .cfg_q (cfg_q)
   );

   outport_ct_latch u_ct (
      .clk        (clk),
      .rst_n      (rst_n),
      .timer_mode (ct_timer_mode),
      .sq_wave    (ct_sq_wave),
      .tc         (ct_tc),
      .stop       (ct_stop),
      .hold_q     (ct_hold),
      .ct_out     (ct_out)
   );

   outport_pin_sel #(
      .DW(DW), .STAT_W(STAT_W), .CSEL_W(CSEL_W),
      .ATX_BIT(ATX_BIT), .ARX_BIT(ARX_BIT), .BTX_BIT(BTX_BIT), .BRX_BIT(BRX_BIT)
   ) u_sel (
      .cfg    (cfg_q),
      .dat    (dat_q),
      .stat   (irq_stat),
      .ct_out (ct_out),
      .a_csel (a_clk_sel),
      .a_tx16 (a_tx16_clk),
      .a_tx1  (a_tx1_clk),
      .a_rx1  (a_rx1_clk),
      .b_tx1  (b_tx1_clk),
      .b_rx1  (b_rx1_clk),
      .src    (src)
   );

   outport_od_drv #(.DW(DW)) u_drv (
      .src     (src),
      .pin_val (pin_val),
      .pin_oe  (pin_oe)
   );

endmodule

// File: rtl/outport_mux_chk.sv
module outport_mux_chk #(
   parameter int unsigned DW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          bus_we,
   input logic          bus_addr,
   input logic [DW-1:0] bus_wdata,
   input logic          ct_tc,
   input logic          ct_stop,
   input logic          ct_hold,
   input logic [DW-1:0] dat_q,
   input logic [DW-1:0] cfg_q,
   input logic [DW-1:0] pin_val,
   input logic [DW-1:0] pin_oe
);

   AST_WR_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && !bus_addr) |=> (dat_q == $past(bus_wdata))); // R2

   AST_WR_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr) |=> (cfg_q == $past(bus_wdata))); // R2

   AST_NO_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_we |=> ($stable(dat_q) && $stable(cfg_q))); // R2

   AST_LOW_PINS_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |-> ((pin_val[1:0] == ~dat_q[1:0]) && (pin_oe[1:0] == 2'b11))); // R3

   AST_IRQ_OPEN_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_q[7] |-> (pin_oe[7] != pin_val[7])); // R5

   AST_DATA_PUSH_PULL: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_q[3:2] != 2'b01) |-> pin_oe[3]); // R5

   AST_TC_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (ct_tc && !ct_stop) |=> !ct_hold); // R8

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!ct_tc && !ct_stop) |=> $stable(ct_hold)); // R8

   AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      ct_stop |=> ct_hold); // R9

endmodule

bind outport_mux outport_mux_chk #(.DW(DW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .ct_tc     (ct_tc),
   .ct_stop   (ct_stop),
   .ct_hold   (ct_hold),
   .dat_q     (dat_q),
   .cfg_q     (cfg_q),
   .pin_val   (pin_val),
   .pin_oe    (pin_oe)
);

// File: tb/outport_mux_test.sv
`timescale 1ns/1ps
module outport_mux_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_we = 1'b0;
   logic       bus_addr = 1'b0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] irq_stat = 8'h00;
   logic       ct_timer_mode = 1'b0;
   logic       ct_sq_wave = 1'b0;
   logic       ct_tc = 1'b0;
   logic       ct_stop = 1'b0;
   logic [3:0] a_clk_sel = 4'h0;
   logic       a_tx16_clk = 1'b0;
   logic       a_tx1_clk = 1'b0;
   logic       a_rx1_clk = 1'b0;
   logic       b_tx1_clk = 1'b0;
   logic       b_rx1_clk = 1'b0;
   logic [7:0] pin_val;
   logic [7:0] pin_oe;

   int checks = 0;
   int errors = 0;

   logic [7:0] m_dat = 8'h00;
   logic [7:0] m_cfg = 8'h00;
   logic       m_hold = 1'b1;

   always #2.5 clk = ~clk;

   outport_mux uut (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .irq_stat(irq_stat), .ct_timer_mode(ct_timer_mode),
      .ct_sq_wave(ct_sq_wave), .ct_tc(ct_tc), .ct_stop(ct_stop),
      .a_clk_sel(a_clk_sel), .a_tx16_clk(a_tx16_clk), .a_tx1_clk(a_tx1_clk),
      .a_rx1_clk(a_rx1_clk), .b_tx1_clk(b_tx1_clk), .b_rx1_clk(b_rx1_clk),
      .pin_val(pin_val), .pin_oe(pin_oe)
   );

   // Expected drive value and open-drain flag of one pin.
   function automatic logic [1:0] exp_pin(input int p);
      logic v;
      logic od;
      logic ct;
      od = 1'b0;
      ct = ct_timer_mode ? ct_sq_wave : m_hold;
      case (p)
         2: case (m_cfg[1:0])
               2'b00: v = ~m_dat[2];
               2'b01: v = (a_clk_sel == 4'hF) ? a_tx1_clk : a_tx16_clk;
               2'b10: v = a_tx1_clk;
               default: v = a_rx1_clk;
            endcase
         3: case (m_cfg[3:2])
               2'b00: v = ~m_dat[3];
               2'b01: begin v = ct; od = 1'b1; end
               2'b10: v = b_tx1_clk;
               default: v = b_rx1_clk;
            endcase
         4: if (m_cfg[4]) begin v = ~irq_stat[1]; od = 1'b1; end else v = ~m_dat[4];
         5: if (m_cfg[5]) begin v = ~irq_stat[5]; od = 1'b1; end else v = ~m_dat[5];
         6: if (m_cfg[6]) begin v = ~irq_stat[0]; od = 1'b1; end else v = ~m_dat[6];
         7: if (m_cfg[7]) begin v = ~irq_stat[4]; od = 1'b1; end else v = ~m_dat[7];
         default: v = ~m_dat[p];
      endcase
      return {v, od ? ~v : 1'b1};
   endfunction

   function automatic string auto_tag(input int p);
      if (p < 2) return "R3";
      if (p == 2) return "R7";
      if (p == 3) return (m_cfg[3:2] == 2'b01) ? (ct_timer_mode ? "R10" : "R8") : "R6";
      return m_cfg[p] ? "R4" : "R2";
   endfunction

   task automatic check_pins(input string tag);
      for (int p = 0; p < 8; p++) begin
         logic [1:0] e;
         string      t;
         e = exp_pin(p);
         t = (tag == "") ? auto_tag(p) : tag;
         checks++;
         if ({pin_val[p], pin_oe[p]} !== e) begin
            errors++;
            $display("FAIL %s pin %0d: val/oe actual %b%b expected %b%b",
                     t, p, pin_val[p], pin_oe[p], e[1], e[0]);
         end
      end
   endtask

   // Inputs are already set at the falling edge; check, then clock and update the model.
   task automatic step(input string tag);
      #1;
      check_pins(tag);
      @(posedge clk);
      if (bus_we && !bus_addr) m_dat = bus_wdata;
      if (bus_we && bus_addr)  m_cfg = bus_wdata;
      if (ct_stop)      m_hold = 1'b1;
      else if (ct_tc)   m_hold = 1'b0;
      @(negedge clk);
      bus_we  = 1'b0;
      ct_tc   = 1'b0;
      ct_stop = 1'b0;
   endtask

   task automatic wr(input logic a, input logic [7:0] d, input string tag);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      step(tag);
   endtask

   initial begin
      #400000;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'h0C0FFEE5));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state, all pins high and driven
      step("R1");

      // R2: data write reaches pins, no-strobe cycle changes nothing
      wr(1'b0, 8'hA5, "R2");
      bus_addr = 1'b0; bus_wdata = 8'hFF; step("R2");
      bus_addr = 1'b1; bus_wdata = 8'hFF; step("R2");

      // R3: pins 0/1 ignore the mode register
      wr(1'b1, 8'hFF, "R3");
      step("R3");

      // R4 / R5 / R11: interrupt routing, open-drain, unrouted status bits ignored
      wr(1'b1, 8'hF0, "R4");
      irq_stat = 8'h33; step("R4");
      irq_stat = 8'h00; step("R5");
      irq_stat = 8'hCC; step("R11");
      irq_stat = 8'h44; step("R11");

      // R7: pin 2 mode 01 with and without the 1x substitution
      wr(1'b1, 8'h01, "R7");
      a_tx16_clk = 1'b1; a_tx1_clk = 1'b0; a_clk_sel = 4'hE; step("R7");
      a_clk_sel = 4'hF; step("R7");
      a_tx16_clk = 1'b0; a_tx1_clk = 1'b1; step("R7");

      // R6: pin 3 clock sources
      wr(1'b1, 8'h08, "R6");
      b_tx1_clk = 1'b1; b_rx1_clk = 1'b0; step("R6");
      wr(1'b1, 8'h0C, "R6");
      step("R6");

      // R8: counter latch falls on terminal count, rises on stop
      wr(1'b1, 8'h04, "R8");
      ct_timer_mode = 1'b0;
      ct_tc = 1'b1; step("R8");
      step("R8");
      step("R8");
      ct_stop = 1'b1; step("R8");
      step("R8");
      // R9: simultaneous pulses leave the output high
      ct_tc = 1'b1; ct_stop = 1'b1; step("R9");
      step("R9");
      ct_tc = 1'b1; step("R9");
      ct_tc = 1'b1; ct_stop = 1'b1; step("R9");
      step("R9");

      // R10: timer mode follows the square wave
      ct_timer_mode = 1'b1;
      ct_sq_wave = 1'b0; step("R10");
      ct_sq_wave = 1'b1; step("R10");
      ct_sq_wave = 1'b0; step("R10");

      // Constrained random mix
      for (int i = 0; i < 600; i++) begin
         bus_we        = ($urandom % 4) == 0;
         bus_addr      = $urandom % 2;
         bus_wdata     = 8'($urandom);
         irq_stat      = 8'($urandom);
         ct_tc         = ($urandom % 8) == 0;
         ct_stop       = ($urandom % 10) == 0;
         if (($urandom % 16) == 0) ct_timer_mode = ~ct_timer_mode;
         ct_sq_wave    = $urandom % 2;
         a_clk_sel     = (($urandom % 4) == 0) ? 4'hF : 4'($urandom);
         a_tx16_clk    = $urandom % 2;
         a_tx1_clk     = $urandom % 2;
         a_rx1_clk     = $urandom % 2;
         b_tx1_clk     = $urandom % 2;
         b_rx1_clk     = $urandom % 2;
         step("");
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule